// File: doc/BRIEF.md
# Dual-Modulus Prescaler Counter

This block divides its input clock by one of two neighbouring ratios: 11 or 10 in the default build, and 6 or 5 when the `SMALL` parameter is set. A pair of mode inputs picks the ratio. A slower external counter drives the mode inputs and "swallows" single clock periods at chosen moments. That lets a fast front stage plus slow control logic build large programmable division ratios.

Internally, a three-stage Johnson shift counter walks through six states, and a toggle stage flips each time the counter reaches its last state. The next high phase starts at a state chosen by the mode inputs. So the length of the coming output period is fixed on the single edge where the output rises. Any later movement on the mode inputs, glitches included, cannot change it. An asynchronous master-set input forces every stage high and overrides all other inputs. An active-low enable freezes the count.

Top module: `dual_mod_prescaler`

## Requirements
- R1: With `SMALL`=0 and both mode inputs low, `div_out` stays high for 6 clock periods and low for 5 (ratio 11).
- R2: With `SMALL`=0 and either mode input high, `div_out` stays high for 5 clock periods and low for 5 (ratio 10).
- R3: The mode inputs take effect only on the clock edge where `div_out` rises; that edge fixes the length of the high phase that begins there, and mode changes on any other edge have no effect on the output.
- R4: While `mset` is high, `div_out` is 1 at once without waiting for a clock, whatever the enable and mode inputs. After `mset` falls, the output stays high and falls on the third enabled clock edge.
- R5: While `cnt_en_n` is high (and `mset` low), clock edges leave the counter and the output unchanged.
- R6: `div_out_n` is always the logical inverse of `div_out`.
- R7: With `SMALL`=1, the low phase is 3 periods and the high phase is 3 periods when both mode inputs are low (ratio 6) or 2 periods otherwise (ratio 5).
- R8: The counter only ever holds one of the six Johnson codes. A high phase starts in the long or short start state, and a low phase starts in the fixed low start state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| cnt_en_n | input | 1 | Count enable, active low; high holds the state |
| mset | input | 1 | Asynchronous master set, active high, forces all stages high |
| mode_a | input | 1 | Mode select; high selects the shorter ratio |
| mode_b | input | 1 | Mode select; high selects the shorter ratio |
| div_out | output | 1 | Divided clock output |
| div_out_n | output | 1 | Inverse of `div_out` |

## Verification
The assertions assume that the mode and enable inputs are synchronous to `clk` and settle well before each rising edge. They also assume that `mset` is high at time zero and is released away from a rising edge. The bench changes every input on the falling clock edge, which meets all of these assumptions. This holds even when the mode inputs are re-randomised every cycle or the set pulse arrives mid-period. Period lengths are measured only over stretches with the count enabled throughout, so a hold never appears as a wrong ratio.

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler #(
  parameter bit SMALL = 1'b0
) (
  input  logic clk,
  input  logic cnt_en_n,
  input  logic mset,
  input  logic mode_a,
  input  logic mode_b,
  output logic div_out,
  output logic div_out_n
);

  localparam int LOW_LEN  = SMALL ? 3 : 5;
  localparam int HI_SHORT = SMALL ? 2 : 5;
  localparam int HI_LONG  = HI_SHORT + 1;

  function automatic logic [2:0] jcode(input int idx);
    case (idx)
      0:       return 3'b000;
      1:       return 3'b001;
      2:       return 3'b011;
      3:       return 3'b111;
      4:       return 3'b110;
      default: return 3'b100;
    endcase
  endfunction

  localparam logic [2:0] LAST        = jcode(5);
  localparam logic [2:0] LOW_START   = jcode(6 - LOW_LEN);
  localparam logic [2:0] SHORT_START = jcode(6 - HI_SHORT);
  localparam logic [2:0] LONG_START  = jcode(6 - HI_LONG);

  logic [2:0] sh, nxt_sh;
  logic       tog;

  wire at_last  = (sh == LAST);
  wire bad      = (sh == 3'b010) || (sh == 3'b101);
  wire long_sel = ~(mode_a | mode_b);

  always_comb begin
    if (bad)
      nxt_sh = LAST;
    else if (at_last)
      nxt_sh = tog ? LOW_START : (long_sel ? LONG_START : SHORT_START);
    else
      nxt_sh = {sh[1:0], ~sh[2]};
  end

  always_ff @(posedge clk or posedge mset) begin
    if (mset) begin
      sh  <= 3'b111;
      tog <= 1'b1;
    end else if (!cnt_en_n) begin
      sh <= nxt_sh;
      if (at_last) tog <= ~tog;
    end
  end

  assign div_out   = tog;
  assign div_out_n = ~tog;

  // R5
  hold_state_chk: assert property (@(posedge clk) disable iff (mset)
    cnt_en_n |=> ($stable(sh) && $stable(tog)));

  // R8
  legal_code_chk: assert property (@(posedge clk) disable iff (mset)
    (sh != 3'b010) && (sh != 3'b101));

  // R8
  high_start_chk: assert property (@(posedge clk) disable iff (mset)
    $rose(tog) |-> (sh == LONG_START || sh == SHORT_START));

  // R8
  low_start_chk: assert property (@(posedge clk) disable iff (mset)
    $fell(tog) |-> (sh == LOW_START));

  // R3
  rise_from_last_chk: assert property (@(posedge clk) disable iff (mset)
    $rose(tog) |-> ($past(sh) == LAST));

endmodule

// File: tb/dual_mod_prescaler_test.sv
`timescale 1ns/1ps
module dual_mod_prescaler_test;
  logic clk = 1'b0;
  logic cnt_en_n = 1'b0;
  logic mset = 1'b1;
  logic mode_a = 1'b0;
  logic mode_b = 1'b0;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  for (genvar g = 0; g < 2; g++) begin : lane
    localparam int LO = (g == 1) ? 3 : 5;
    localparam int HS = (g == 1) ? 2 : 5;
    localparam int HL = HS + 1;
    logic q, qn;
    dual_mod_prescaler #(.SMALL(g == 1)) uut (
      .clk(clk), .cnt_en_n(cnt_en_n), .mset(mset),
      .mode_a(mode_a), .mode_b(mode_b), .div_out(q), .div_out_n(qn));

    bit mout;
    int mrem;
    bit edge_long, edge_en;
    always @(posedge clk) begin
      edge_long = !(mode_a | mode_b);
      edge_en   = !cnt_en_n;
      if (mset) begin
        mout = 1'b1; mrem = 3;
      end else if (!cnt_en_n) begin
        if (mrem == 1) begin
          mout = !mout;
          mrem = mout ? (edge_long ? HL : HS) : LO;
        end else mrem--;
      end
    end

    bit last_q, clean, hi_long;
    int run;
    always @(negedge clk) begin
      #1;
      if (!done) begin
        checks++;
        if (mset) begin
          if (q !== 1'b1) begin errors++; $display("FAIL R4 lane%0d set: got %b expected 1", g, q); end
        end else if (q !== (mset ? 1'b1 : mout)) begin
          errors++;
          $display("FAIL %s lane%0d: got %b expected %b", edge_en ? "R3" : "R5", g, q, mout);
        end
        checks++;
        if (qn !== ~q) begin errors++; $display("FAIL R6 lane%0d: got %b expected %b", g, qn, ~q); end
        if (mset) begin
          clean = 0; run = 0; last_q = 1'b1;
        end else begin
          if (!edge_en) clean = 0;
          if (q == last_q) run++;
          else begin
            if (clean) begin
              checks++;
              if (last_q) begin
                if (run != (hi_long ? HL : HS)) begin
                  errors++;
                  $display("FAIL %s lane%0d high: got %0d expected %0d", g ? "R7" : (hi_long ? "R1" : "R2"), g, run, hi_long ? HL : HS);
                end
              end else if (run != LO) begin
                errors++;
                $display("FAIL %s lane%0d low: got %0d expected %0d", g ? "R7" : "R1", g, run, LO);
              end
            end
            if (q) hi_long = edge_long;
            clean = edge_en; run = 1; last_q = q;
          end
        end
      end
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    wait_cycles(3);
    mset = 1'b0;
    wait_cycles(70);
    mode_a = 1'b1;
    wait_cycles(70);
    mode_a = 1'b0; mode_b = 1'b1;
    wait_cycles(70);
    mode_a = 1'b1;
    wait_cycles(70);
    for (int i = 0; i < 800; i++) begin
      mode_a = $urandom_range(0, 1);
      mode_b = ($urandom_range(0, 3) == 0);
      @(negedge clk);
    end
    for (int k = 0; k < 10; k++) begin
      cnt_en_n = 1'b1;
      mode_a = $urandom_range(0, 1);
      mode_b = 1'b0;
      wait_cycles(7 + k);
      cnt_en_n = 1'b0;
      wait_cycles(35);
    end
    for (int k = 0; k < 6; k++) begin
      mset = 1'b1;
      cnt_en_n = k[0];
      wait_cycles(2);
      mset = 1'b0;
      cnt_en_n = 1'b0;
      for (int i = 0; i < 40 + 3 * k; i++) begin
        mode_a = $urandom_range(0, 1);
        mode_b = $urandom_range(0, 1);
        @(negedge clk);
      end
    end
    mode_a = 1'b0; mode_b = 1'b0;
    wait_cycles(60);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule